// File: doc/BRIEF.md
# Banked I/O Port Decoder

This block sits between a processor bus and a small set of byte-wide peripherals in a separate I/O address space. The bus has a 16-bit data path split into a low byte lane and a high byte lane. On each I/O bus cycle the decoder compares the full 16-bit port address. From that comparison it drives active-low selects for an aligned group of eight byte ports, one write strobe per byte lane for a pair of adjacent output ports, and a single read enable for a 16-bit buffered input port.

The two write strobes load two 8-bit output registers. These registers hold their value until the next write to the same port. The two adjacent output ports can therefore be written one at a time with byte writes, or together with one word write to the even address. Reads use no per-lane strobe: the input buffer is enabled for the whole word and the processor takes the lane it needs. When the input port is not addressed, the read data output is zero and the valid flag is low.

Address decoding and strobe generation are combinational. The output registers use the system clock, with the decoded write strobe acting as the load enable.

Top module: `io_bank_decoder`

## Requirements
- R1: Every address bit takes part in decoding. A port with a base in the 00H–FFH range matches only when `addr[15:8]` is 00H, so 12F3H, 01F0H and 4040H select nothing.
- R2: `grp_sel_n[i]` goes low on an I/O read or write to port `GRP_BASE + i` (default group F0H–F7H), with bit i matching address offset i. At most one bit is low at a time.
- R3: Bank selection uses `addr[0]` and `hi_en`. A byte write to the even output port (40H, `hi_en`=0) drives only `wr_lo_n` low. A byte write to the odd port (41H, `hi_en`=1) drives only `wr_hi_n` low. An access to 41H with `hi_en`=0 drives neither strobe.
- R4: A word write to 40H with `hi_en`=1 drives both write strobes in the same cycle, and both output registers load on the same clock edge.
- R5: At a rising clock edge where `wr_lo_n` is low, `lat_lo` takes `wdata[7:0]`. At a rising clock edge where `wr_hi_n` is low, `lat_hi` takes `wdata[15:8]`. Otherwise each register keeps its value.
- R6: An I/O read of 64H or 65H drives `rd_en_n` low whatever the value of `hi_en`. A read never drives a write strobe, and a write never drives `rd_en_n`.
- R7: No select, strobe or enable is active in a memory cycle (`io_cycle`=0), in an idle cycle (neither `rd` nor `wr`), or when `rd` and `wr` are both high.
- R8: While `rd_en_n` is low, `rdata` equals `in_data` and `rdata_vld` is 1. Otherwise `rdata` is 0000H and `rdata_vld` is 0.
- R9: A synchronous active-high `rst` clears both output registers to 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Port address |
| hi_en | input | 1 | High byte lane enable, active high |
| io_cycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| wdata | input | 16 | Write data; low lane [7:0], high lane [15:8] |
| in_data | input | 16 | Data presented by the buffered input port |
| grp_sel_n | output | 8 | Active-low selects for the eight-port group |
| wr_lo_n | output | 1 | Active-low low-lane write strobe (port 40H) |
| wr_hi_n | output | 1 | Active-low high-lane write strobe (port 41H) |
| rd_en_n | output | 1 | Active-low read enable of the input buffer (64H/65H) |
| lat_lo | output | 8 | Output register of port 40H |
| lat_hi | output | 8 | Output register of port 41H |
| rdata | output | 16 | Read data returned to the bus |
| rdata_vld | output | 1 | Read data valid |

## Verification
The two lane write strobes, and the two register loads behind them, can occur in the same cycle. This happens on a word write to 40H with `hi_en` set. The bench writes distinct byte values into the two lanes and checks that both registers take their own lane at the one clock edge. It also checks that byte writes to 40H and to 41H each change only their own register. A table of bus cycles covers the strobe combinations for every pairing of `addr[0]` and `hi_en`.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Only a clean I/O read or a clean I/O write counts; anything else is inert.
  function automatic cyc_e classify(input logic io, input logic rd, input logic wr);
    if (!io)
      return CYC_NONE;
    if (rd && !wr)
      return CYC_READ;
    if (wr && !rd)
      return CYC_WRITE;
    return CYC_NONE;
  endfunction

endpackage

// File: rtl/io_addr_match.sv
module io_addr_match #(
  parameter int              HI_W    = 13,
  parameter logic [HI_W-1:0] BASE_HI = '0
) (
  input  logic [HI_W-1:0] addr_hi,
  output logic            hit
);
  assign hit = (addr_hi == BASE_HI);
endmodule

// File: rtl/io_group_select.sv
module io_group_select #(
  parameter int PORTS = 8,
  localparam int IDX_W = $clog2(PORTS)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [PORTS-1:0] sel_n
);
  for (genvar i = 0; i < PORTS; i++) begin : g_sel
    assign sel_n[i] = ~(en && (idx == IDX_W'(i)));
  end
endmodule

// File: rtl/io_bank_strobe.sv
module io_bank_strobe (
  input  logic wr_hit,
  input  logic a0,
  input  logic hi_en,
  output logic wr_lo_n,
  output logic wr_hi_n
);
  // Low lane follows an even address, high lane follows the high-bank enable.
  assign wr_lo_n = ~(wr_hit && !a0);
  assign wr_hi_n = ~(wr_hit && hi_en);
endmodule

// File: rtl/io_byte_latch.sv
module io_byte_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (!ld_n)
      q <= d;
  end
endmodule

// File: rtl/io_bank_decoder.sv
module io_bank_decoder
  import io_dec_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              LANE_W    = 8,
  parameter int              GRP_PORTS = 8,
  parameter logic [ADDR_W-1:0] GRP_BASE = 16'h00F0,
  parameter logic [ADDR_W-1:0] OUT_BASE = 16'h0040,
  parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0064,
  localparam int DATA_W    = 2 * LANE_W,
  localparam int GRP_IDX_W = $clog2(GRP_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 hi_en,
  input  logic                 io_cycle,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    in_data,
  output logic [GRP_PORTS-1:0] grp_sel_n,
  output logic                 wr_lo_n,
  output logic                 wr_hi_n,
  output logic                 rd_en_n,
  output logic [LANE_W-1:0]    lat_lo,
  output logic [LANE_W-1:0]    lat_hi,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rdata_vld
);

  cyc_e cyc;
  logic is_rd, is_wr, any_acc;
  logic grp_hit, out_hit, in_hit;

  assign cyc     = classify(io_cycle, rd, wr);
  assign is_rd   = (cyc == CYC_READ);
  assign is_wr   = (cyc == CYC_WRITE);
  assign any_acc = is_rd || is_wr;

  // Full-width comparisons; low bits that index within a region are excluded.
  io_addr_match #(
    .HI_W   (ADDR_W - GRP_IDX_W),
    .BASE_HI(GRP_BASE[ADDR_W-1:GRP_IDX_W])
  ) u_grp_match (
    .addr_hi(addr[ADDR_W-1:GRP_IDX_W]),
    .hit    (grp_hit)
  );

  io_addr_match #(
    .HI_W   (ADDR_W - 1),
    .BASE_HI(OUT_BASE[ADDR_W-1:1])
  ) u_out_match (
    .addr_hi(addr[ADDR_W-1:1]),
    .hit    (out_hit)
  );

  io_addr_match #(
    .HI_W   (ADDR_W - 1),
    .BASE_HI(IN_BASE[ADDR_W-1:1])
  ) u_in_match (
    .addr_hi(addr[ADDR_W-1:1]),
    .hit    (in_hit)
  );

  io_group_select #(
    .PORTS(GRP_PORTS)
  ) u_grp_sel (
    .en   (grp_hit && any_acc),
    .idx  (addr[GRP_IDX_W-1:0]),
    .sel_n(grp_sel_n)
  );

  io_bank_strobe u_strobe (
    .wr_hit (out_hit && is_wr),
    .a0     (addr[0]),
    .hi_en  (hi_en),
    .wr_lo_n(wr_lo_n),
    .wr_hi_n(wr_hi_n)
  );

  // Word-wide input port: enable ignores the lane enables.
  assign rd_en_n   = ~(in_hit && is_rd);
  assign rdata     = rd_en_n ? '0 : in_data;
  assign rdata_vld = ~rd_en_n;

  logic [1:0]        lane_ld_n;
  logic [LANE_W-1:0] lane_q [2];

  assign lane_ld_n = {wr_hi_n, wr_lo_n};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    io_byte_latch #(
      .W(LANE_W)
    ) u_latch (
      .clk (clk),
      .rst (rst),
      .ld_n(lane_ld_n[g]),
      .d   (wdata[g*LANE_W +: LANE_W]),
      .q   (lane_q[g])
    );
  end

  assign lat_lo = lane_q[0];
  assign lat_hi = lane_q[1];

endmodule

// File: rtl/io_bank_decoder_chk.sv
module io_bank_decoder_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                LANE_W    = 8,
  parameter int                GRP_PORTS = 8,
  parameter logic [ADDR_W-1:0] GRP_BASE  = 16'h00F0,
  localparam int DATA_W    = 2 * LANE_W,
  localparam int GRP_IDX_W = $clog2(GRP_PORTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    addr,
  input logic                 io_cycle,
  input logic                 rd,
  input logic                 wr,
  input logic [DATA_W-1:0]    wdata,
  input logic [GRP_PORTS-1:0] grp_sel_n,
  input logic                 wr_lo_n,
  input logic                 wr_hi_n,
  input logic                 rd_en_n,
  input logic [LANE_W-1:0]    lat_lo,
  input logic [LANE_W-1:0]    lat_hi,
  input logic [DATA_W-1:0]    rdata,
  input logic                 rdata_vld
);

  AST_INERT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!io_cycle || (rd == wr)) |-> (&grp_sel_n && wr_lo_n && wr_hi_n && rd_en_n)); // R7

  AST_GROUP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~grp_sel_n)); // R2

  AST_GROUP_FULL_ADDR: assert property (@(posedge clk) disable iff (rst)
    !(&grp_sel_n) |-> (addr[ADDR_W-1:GRP_IDX_W] == GRP_BASE[ADDR_W-1:GRP_IDX_W])); // R1

  AST_ODD_NO_LOW: assert property (@(posedge clk) disable iff (rst)
    addr[0] |-> wr_lo_n); // R3

  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    !wr_lo_n |=> (lat_lo == $past(wdata[LANE_W-1:0]))); // R5

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_lo_n |=> $stable(lat_lo)); // R5

  AST_HIGH_LOAD: assert property (@(posedge clk) disable iff (rst)
    !wr_hi_n |=> (lat_hi == $past(wdata[DATA_W-1:LANE_W]))); // R5

  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_hi_n |=> $stable(lat_hi)); // R5

  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !rd_en_n |-> (wr_lo_n && wr_hi_n)); // R6

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en_n |-> ((rdata == '0) && !rdata_vld)); // R8

endmodule

bind io_bank_decoder io_bank_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .LANE_W   (LANE_W),
  .GRP_PORTS(GRP_PORTS),
  .GRP_BASE (GRP_BASE)
) u_chk (.*);

// File: tb/io_bank_decoder_tb.sv
module io_bank_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        hi_en = 1'b0;
  logic        io_cycle = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] in_data = '0;
  logic [7:0]  grp_sel_n;
  logic        wr_lo_n, wr_hi_n, rd_en_n;
  logic [7:0]  lat_lo, lat_hi;
  logic [15:0] rdata;
  logic        rdata_vld;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  io_bank_decoder u_dut (
    .clk(clk), .rst(rst), .addr(addr), .hi_en(hi_en), .io_cycle(io_cycle),
    .rd(rd), .wr(wr), .wdata(wdata), .in_data(in_data),
    .grp_sel_n(grp_sel_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
    .rd_en_n(rd_en_n), .lat_lo(lat_lo), .lat_hi(lat_hi),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {req, io, rd, wr, hi_en, addr, sel_n, wr_lo_n, wr_hi_n, rd_en_n}
  localparam int NV = 20;
  localparam logic [34:0] VEC [NV] = '{
    {4'd2, 1'b1,1'b1,1'b0,1'b0, 16'h00F0, 8'hFE, 1'b1,1'b1,1'b1}, // R2 first port
    {4'd2, 1'b1,1'b0,1'b1,1'b0, 16'h00F7, 8'h7F, 1'b1,1'b1,1'b1}, // R2 last port
    {4'd2, 1'b1,1'b1,1'b0,1'b0, 16'h00F5, 8'hDF, 1'b1,1'b1,1'b1}, // R2 middle
    {4'd1, 1'b1,1'b1,1'b0,1'b0, 16'h12F3, 8'hFF, 1'b1,1'b1,1'b1}, // R1 upper byte set
    {4'd1, 1'b1,1'b0,1'b1,1'b0, 16'h01F0, 8'hFF, 1'b1,1'b1,1'b1}, // R1
    {4'd7, 1'b0,1'b1,1'b0,1'b0, 16'h00F3, 8'hFF, 1'b1,1'b1,1'b1}, // R7 memory
    {4'd7, 1'b1,1'b0,1'b0,1'b0, 16'h00F2, 8'hFF, 1'b1,1'b1,1'b1}, // R7 idle
    {4'd7, 1'b1,1'b1,1'b1,1'b0, 16'h00F1, 8'hFF, 1'b1,1'b1,1'b1}, // R7 rd+wr
    {4'd3, 1'b1,1'b0,1'b1,1'b0, 16'h0040, 8'hFF, 1'b0,1'b1,1'b1}, // R3 even byte
    {4'd3, 1'b1,1'b0,1'b1,1'b1, 16'h0041, 8'hFF, 1'b1,1'b0,1'b1}, // R3 odd byte
    {4'd3, 1'b1,1'b0,1'b1,1'b0, 16'h0041, 8'hFF, 1'b1,1'b1,1'b1}, // R3 odd no hi_en
    {4'd4, 1'b1,1'b0,1'b1,1'b1, 16'h0040, 8'hFF, 1'b0,1'b0,1'b1}, // R4 word
    {4'd1, 1'b1,1'b0,1'b1,1'b1, 16'h4040, 8'hFF, 1'b1,1'b1,1'b1}, // R1 alias
    {4'd6, 1'b1,1'b1,1'b0,1'b1, 16'h0040, 8'hFF, 1'b1,1'b1,1'b1}, // R6 read no strobe
    {4'd6, 1'b1,1'b1,1'b0,1'b0, 16'h0064, 8'hFF, 1'b1,1'b1,1'b0}, // R6
    {4'd6, 1'b1,1'b1,1'b0,1'b1, 16'h0065, 8'hFF, 1'b1,1'b1,1'b0}, // R6
    {4'd6, 1'b1,1'b1,1'b0,1'b1, 16'h0064, 8'hFF, 1'b1,1'b1,1'b0}, // R6
    {4'd6, 1'b1,1'b0,1'b1,1'b1, 16'h0064, 8'hFF, 1'b1,1'b1,1'b1}, // R6 write
    {4'd7, 1'b0,1'b0,1'b1,1'b1, 16'h0040, 8'hFF, 1'b1,1'b1,1'b1}, // R7 memory
    {4'd7, 1'b1,1'b1,1'b1,1'b0, 16'h0064, 8'hFF, 1'b1,1'b1,1'b1}  // R7 rd+wr
  };

  // One bus cycle, then idle; registers are sampled after the capturing edge.
  task automatic bus(input logic i, input logic r, input logic w, input logic h,
                     input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_cycle = i; rd = r; wr = w; hi_en = h; addr = a; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; io_cycle = 1'b0; addr = 16'h0000;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9", "lat_lo after reset", 32'(lat_lo), 32'h00);
    check("R9", "lat_hi after reset", 32'(lat_hi), 32'h00);
    check("R8", "rdata_vld idle", 32'(rdata_vld), 32'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {io_cycle, rd, wr, hi_en, addr} = VEC[k][30:11];
      #1;
      check($sformatf("R%0d", VEC[k][34:31]), $sformatf("row %0d sel_n", k),
            32'(grp_sel_n), 32'(VEC[k][10:3]));
      check($sformatf("R%0d", VEC[k][34:31]), $sformatf("row %0d wr_lo_n", k),
            32'(wr_lo_n), 32'(VEC[k][2]));
      check($sformatf("R%0d", VEC[k][34:31]), $sformatf("row %0d wr_hi_n", k),
            32'(wr_hi_n), 32'(VEC[k][1]));
      check($sformatf("R%0d", VEC[k][34:31]), $sformatf("row %0d rd_en_n", k),
            32'(rd_en_n), 32'(VEC[k][0]));
    end

    // R8 read data path
    @(negedge clk);
    in_data = 16'hA55A; io_cycle = 1'b1; rd = 1'b1; wr = 1'b0; hi_en = 1'b0; addr = 16'h0065;
    #1;
    check("R8", "rdata on input port", 32'(rdata), 32'hA55A);
    check("R8", "rdata_vld on input port", 32'(rdata_vld), 32'h1);
    addr = 16'h00F0;
    #1;
    check("R8", "rdata elsewhere", 32'(rdata), 32'h0000);
    check("R8", "rdata_vld elsewhere", 32'(rdata_vld), 32'h0);
    @(negedge clk);
    rd = 1'b0; io_cycle = 1'b0;

    // Make latch contents known, then exercise lanes
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;

    bus(1'b1, 1'b0, 1'b1, 1'b0, 16'h0040, 16'h1234);
    check("R3", "even byte lat_lo", 32'(lat_lo), 32'h34);
    check("R3", "even byte lat_hi", 32'(lat_hi), 32'h00);

    bus(1'b1, 1'b0, 1'b1, 1'b1, 16'h0041, 16'hAB99);
    check("R3", "odd byte lat_hi", 32'(lat_hi), 32'hAB);
    check("R5", "odd byte keeps lat_lo", 32'(lat_lo), 32'h34);

    bus(1'b1, 1'b0, 1'b1, 1'b1, 16'h0040, 16'hC3D4);
    check("R4", "word lat_lo", 32'(lat_lo), 32'hD4);
    check("R4", "word lat_hi", 32'(lat_hi), 32'hC3);

    bus(1'b0, 1'b0, 1'b1, 1'b1, 16'h0040, 16'hFFFF);
    check("R7", "memory write lat_lo", 32'(lat_lo), 32'hD4);
    check("R7", "memory write lat_hi", 32'(lat_hi), 32'hC3);

    bus(1'b1, 1'b1, 1'b0, 1'b1, 16'h0040, 16'h5555);
    check("R6", "read lat_lo", 32'(lat_lo), 32'hD4);
    check("R6", "read lat_hi", 32'(lat_hi), 32'hC3);

    bus(1'b1, 1'b0, 1'b1, 1'b0, 16'h0041, 16'h7777);
    check("R3", "odd no hi_en lat_lo", 32'(lat_lo), 32'hD4);
    check("R3", "odd no hi_en lat_hi", 32'(lat_hi), 32'hC3);

    bus(1'b1, 1'b0, 1'b1, 1'b1, 16'h4040, 16'h6666);
    check("R1", "alias lat_lo", 32'(lat_lo), 32'hD4);
    check("R1", "alias lat_hi", 32'(lat_hi), 32'hC3);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check("R9", "lat_lo cleared", 32'(lat_lo), 32'h00);
    check("R9", "lat_hi cleared", 32'(lat_hi), 32'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule